// File: doc/BRIEF.md
# Dual-Endpoint DMA Address Sequencer

This block drives the data path of a single DMA descriptor once it has been fetched. Loading a transfer gives it a source base address, a destination base address, a byte length, and a per-side configuration. That configuration sets the unit width, the number of units granted per device request, the addressing mode, and the identifier of the device whose request line paces that side. The block then issues read beats and write beats on two simple request/acknowledge ports. It moves the bytes through a one-word holding register and counts the outstanding length down to zero.

Each side addresses in one of three ways:

- **Memory mode** steps the address by the unit width on every beat.
- **Fixed FIFO mode** repeats the base address on every beat.
- **Burst FIFO mode** walks upward inside one request group and returns to the base at the start of the next group.

A side whose identifier names a real device moves at most one group of beats per observed request. The two pseudo-device identifiers (always-ready and throttle) make a side free-running. When both sides carry pseudo-device identifiers, the transfer is flagged as memory-to-memory.

Top module: `dma_addr_gen`

## Requirements
- R1: Width codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 is treated as 4 bytes. A read beat carries min(source width, bytes not yet read) bytes, reported on `rd_bytes`.
- R2: Group-size codes: 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats per device request.
- R3: In address mode 0 (and mode 3, which is treated the same), the k-th beat of a side (k from 0) uses base + k × width.
- R4: In address mode 1 every beat of that side uses the base address.
- R5: In address mode 2 the k-th beat uses base + (k mod group size) × width.
- R6: A paced side issues no beat until its device request line has been sampled high while it holds no credit. One such sample permits exactly one group of beats, or fewer if the transfer ends first.
- R7: Device identifiers 31 (always-ready) and 30 (throttle) are unpaced. `mem_to_mem` is high for a transfer exactly when both identifiers are pseudo-devices.
- R8: The write stream reproduces the read stream byte for byte, in order, in the low lanes of `wr_data`. Each write beat carries min(destination width, bytes not yet written) bytes, reported on `wr_bytes`.
- R9: `remaining` equals the length minus the bytes already written. It changes only on an acknowledged write. After the last write, `done` pulses for one cycle, `busy` falls, and `remaining` is 0.
- R10: A start with length 0 produces a one-cycle `done` pulse, no `busy`, and no bus requests.
- R11: A start pulse while `busy` is high is ignored: the running transfer continues with its original configuration.
- R12: A read request and a write request are never raised in the same cycle.
- R13: After reset, `busy`, `done`, `rd_req`, `wr_req` and `remaining` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the configuration and begin a transfer |
| cfg_src_addr | input | ADDR_W | Source base address |
| cfg_dst_addr | input | ADDR_W | Destination base address |
| cfg_len | input | CNT_W | Transfer length in bytes |
| cfg_src_width | input | 2 | Source width code |
| cfg_dst_width | input | 2 | Destination width code |
| cfg_src_tsize | input | 2 | Source group-size code |
| cfg_dst_tsize | input | 2 | Destination group-size code |
| cfg_src_mode | input | 2 | Source address mode |
| cfg_dst_mode | input | 2 | Destination address mode |
| cfg_src_dev | input | DEV_W | Device pacing the source side |
| cfg_dst_dev | input | DEV_W | Device pacing the destination side |
| dev_req | input | DEV_N | Device request lines, one per identifier |
| rd_req | output | 1 | Read beat requested |
| rd_addr | output | ADDR_W | Read beat address |
| rd_bytes | output | BCNT_W | Bytes in the read beat |
| rd_ack | input | 1 | Read beat completes this cycle |
| rd_data | input | DATA_W | Read data, valid with `rd_ack`, low lanes used |
| wr_req | output | 1 | Write beat requested |
| wr_addr | output | ADDR_W | Write beat address |
| wr_bytes | output | BCNT_W | Bytes in the write beat |
| wr_data | output | DATA_W | Write data, low lanes valid |
| wr_ack | input | 1 | Write beat completes this cycle |
| busy | output | 1 | Transfer in progress |
| mem_to_mem | output | 1 | Both sides unpaced for the current transfer |
| remaining | output | CNT_W | Bytes not yet written |
| done | output | 1 | One-cycle pulse at completion |

## Verification
Several rules are checked by assertions on every cycle:

- read and write requests are mutually exclusive;
- the holding register never overfills or underflows;
- a paced side only gains credit right after its request line was high;
- a fixed-mode address never moves, and a memory-mode address steps by one width per beat;
- `remaining` holds between write acknowledgements and is zero when `done` pulses.

The byte ordering through width conversion, the burst address wrap, the exact group size granted per request, and the rejection of a second start can only be shown by scenarios. These scenarios compare every beat's address, size and data lanes with a model of the streams and use randomised acknowledge stalls and request lines.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

    typedef enum logic [1:0] {
        AM_INC   = 2'd0,
        AM_FIXED = 2'd1,
        AM_BURST = 2'd2,
        AM_INC_X = 2'd3
    } addr_mode_e;

    typedef struct packed {
        logic [1:0] width;
        logic [1:0] tsize;
        addr_mode_e mode;
        logic       paced;
    } side_cfg_t;

    // bytes moved by one beat for a width code; unknown code means a full word
    function automatic logic [2:0] unit_bytes_of(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // beats granted per device request for a group-size code
    function automatic logic [3:0] group_beats_of(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            2'd2:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/dma_ag_side.sv
module dma_ag_side
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GRP_W  = 4,
    localparam int IDX_W = GRP_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  side_cfg_t         cfg_in,
    input  logic              req_line,
    input  logic              has_work,
    input  logic              beat,
    output logic [ADDR_W-1:0] addr,
    output logic              go,
    output logic [2:0]        unit_bytes
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] offset_q;
    side_cfg_t         cfg_q;
    logic [GRP_W-1:0]  credit_q;
    logic [IDX_W-1:0]  idx_q;
    logic              grant;

    assign unit_bytes = unit_bytes_of(cfg_q.width);
    assign go         = (credit_q != '0);
    assign grant      = (credit_q == '0) && has_work && (!cfg_q.paced || req_line);

    always_comb begin
        case (cfg_q.mode)
            AM_FIXED: addr = base_q;
            AM_BURST: addr = base_q + ADDR_W'(idx_q) * ADDR_W'(unit_bytes);
            default:  addr = base_q + offset_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            offset_q <= '0;
            cfg_q    <= '0;
            credit_q <= '0;
            idx_q    <= '0;
        end else if (load) begin
            base_q   <= base_in;
            cfg_q    <= cfg_in;
            offset_q <= '0;
            credit_q <= '0;
            idx_q    <= '0;
        end else if (beat) begin
            credit_q <= credit_q - 1'b1;
            idx_q    <= idx_q + 1'b1;
            offset_q <= offset_q + ADDR_W'(unit_bytes);
        end else if (grant) begin
            credit_q <= GRP_W'(group_beats_of(cfg_q.tsize));
            idx_q    <= '0;
        end
    end

    // R6: a paced side gains credit only right after its request line was high
    a_r6_credit_from_request: assert property (@(posedge clk) disable iff (rst)
        ($rose(go) && cfg_q.paced) |-> $past(req_line));

    // R4: the fixed-mode address never moves while the transfer runs
    a_r4_fixed_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == AM_FIXED && !load) |=> addr == $past(addr));

    // R3: memory mode advances by one width per completed beat
    a_r3_inc_step: assert property (@(posedge clk) disable iff (rst)
        (beat && !load && (cfg_q.mode == AM_INC || cfg_q.mode == AM_INC_X))
        |=> addr == $past(addr) + ADDR_W'($past(unit_bytes)));

endmodule

// File: rtl/dma_ag_pack.sv
module dma_ag_pack #(
    parameter int DATA_BYTES = 4,
    localparam int DATA_W = 8 * DATA_BYTES,
    localparam int CNT_W  = $clog2(DATA_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              push,
    input  logic [CNT_W-1:0]  push_bytes,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic [CNT_W-1:0]  pop_bytes,
    output logic [DATA_W-1:0] hold_data,
    output logic [CNT_W-1:0]  hold_cnt
);

    logic [DATA_W-1:0] hold_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] lanes;

    always_comb begin
        lanes = '0;
        for (int b = 0; b < DATA_BYTES; b++) begin
            if (b < int'(push_bytes)) lanes[b*8 +: 8] = 8'hFF;
        end
    end

    assign hold_data = hold_q;
    assign hold_cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hold_q <= '0;
            cnt_q  <= '0;
        end else if (push) begin
            hold_q <= hold_q | ((push_data & lanes) << {cnt_q, 3'b000});
            cnt_q  <= cnt_q + push_bytes;
        end else if (pop) begin
            hold_q <= hold_q >> {pop_bytes, 3'b000};
            cnt_q  <= cnt_q - pop_bytes;
        end
    end

    // R12: a read and a write never complete together
    a_r12_no_push_pop: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

    // R8: the holding word neither overfills nor gives out bytes it lacks
    a_r8_fill_bound: assert property (@(posedge clk) disable iff (rst)
        push |-> (int'(cnt_q) + int'(push_bytes) <= DATA_BYTES));

    a_r8_drain_bound: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt_q >= pop_bytes));

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 16,
    parameter int DEV_N       = 32,
    parameter int ALWAYS_ID   = 31,
    parameter int THROTTLE_ID = 30,
    parameter int DATA_BYTES  = 4,
    localparam int DEV_W  = $clog2(DEV_N),
    localparam int DATA_W = 8 * DATA_BYTES,
    localparam int BCNT_W = $clog2(DATA_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [CNT_W-1:0]  cfg_len,
    input  logic [1:0]        cfg_src_width,
    input  logic [1:0]        cfg_dst_width,
    input  logic [1:0]        cfg_src_tsize,
    input  logic [1:0]        cfg_dst_tsize,
    input  logic [1:0]        cfg_src_mode,
    input  logic [1:0]        cfg_dst_mode,
    input  logic [DEV_W-1:0]  cfg_src_dev,
    input  logic [DEV_W-1:0]  cfg_dst_dev,
    input  logic [DEV_N-1:0]  dev_req,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [BCNT_W-1:0] rd_bytes,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BCNT_W-1:0] wr_bytes,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              busy,
    output logic              mem_to_mem,
    output logic [CNT_W-1:0]  remaining,
    output logic              done
);

    function automatic logic pseudo_dev(input logic [DEV_W-1:0] id);
        return (id == DEV_W'(ALWAYS_ID)) || (id == DEV_W'(THROTTLE_ID));
    endfunction

    logic              busy_q, done_q, m2m_q;
    logic [CNT_W-1:0]  rd_left_q, wr_left_q;
    logic [DEV_W-1:0]  src_dev_q, dst_dev_q;
    logic              load;
    side_cfg_t         src_cfg, dst_cfg;
    logic [2:0]        src_ub, dst_ub;
    logic              src_go, dst_go;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [BCNT_W-1:0] rd_n, wr_need, hold_cnt;
    logic [DATA_W-1:0] hold_data;
    logic              rd_fire, wr_fire;

    assign load = start && !busy_q;

    assign src_cfg = '{width: cfg_src_width, tsize: cfg_src_tsize,
                       mode: addr_mode_e'(cfg_src_mode), paced: !pseudo_dev(cfg_src_dev)};
    assign dst_cfg = '{width: cfg_dst_width, tsize: cfg_dst_tsize,
                       mode: addr_mode_e'(cfg_dst_mode), paced: !pseudo_dev(cfg_dst_dev)};

    // tail beats shrink to the bytes left on that side
    assign rd_n    = (CNT_W'(src_ub) > rd_left_q) ? BCNT_W'(rd_left_q) : BCNT_W'(src_ub);
    assign wr_need = (CNT_W'(dst_ub) > wr_left_q) ? BCNT_W'(wr_left_q) : BCNT_W'(dst_ub);

    assign rd_req  = busy_q && (rd_left_q != '0) && (hold_cnt < wr_need) && src_go;
    assign wr_req  = busy_q && (wr_need != '0) && (hold_cnt >= wr_need) && dst_go;
    assign rd_fire = rd_req && rd_ack;
    assign wr_fire = wr_req && wr_ack;

    assign rd_addr    = src_addr;
    assign rd_bytes   = rd_n;
    assign wr_addr    = dst_addr;
    assign wr_bytes   = wr_need;
    assign wr_data    = hold_data;
    assign busy       = busy_q;
    assign done       = done_q;
    assign mem_to_mem = m2m_q;
    assign remaining  = wr_left_q;

    dma_ag_side #(.ADDR_W(ADDR_W)) u_src (
        .clk(clk), .rst(rst), .load(load), .base_in(cfg_src_addr), .cfg_in(src_cfg),
        .req_line(dev_req[src_dev_q]), .has_work(busy_q && (rd_left_q != '0)),
        .beat(rd_fire), .addr(src_addr), .go(src_go), .unit_bytes(src_ub));

    dma_ag_side #(.ADDR_W(ADDR_W)) u_dst (
        .clk(clk), .rst(rst), .load(load), .base_in(cfg_dst_addr), .cfg_in(dst_cfg),
        .req_line(dev_req[dst_dev_q]), .has_work(busy_q && (wr_left_q != '0)),
        .beat(wr_fire), .addr(dst_addr), .go(dst_go), .unit_bytes(dst_ub));

    dma_ag_pack #(.DATA_BYTES(DATA_BYTES)) u_pack (
        .clk(clk), .rst(rst), .clear(load),
        .push(rd_fire), .push_bytes(rd_n), .push_data(rd_data),
        .pop(wr_fire), .pop_bytes(wr_need),
        .hold_data(hold_data), .hold_cnt(hold_cnt));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            m2m_q     <= 1'b0;
            rd_left_q <= '0;
            wr_left_q <= '0;
            src_dev_q <= '0;
            dst_dev_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                rd_left_q <= cfg_len;
                wr_left_q <= cfg_len;
                busy_q    <= (cfg_len != '0);
                done_q    <= (cfg_len == '0);
                m2m_q     <= pseudo_dev(cfg_src_dev) && pseudo_dev(cfg_dst_dev);
                src_dev_q <= cfg_src_dev;
                dst_dev_q <= cfg_dst_dev;
            end else if (busy_q) begin
                if (rd_fire) rd_left_q <= rd_left_q - CNT_W'(rd_n);
                if (wr_fire) begin
                    wr_left_q <= wr_left_q - CNT_W'(wr_need);
                    if (wr_left_q == CNT_W'(wr_need)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    // R9: the count only moves on an acknowledged write
    a_r9_count_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !wr_fire) |=> remaining == $past(remaining));

    // R9: completion leaves nothing outstanding
    a_r9_done_empty: assert property (@(posedge clk) disable iff (rst)
        done |-> (remaining == '0 && !busy));

    // R1: every read beat moves at least one byte
    a_r1_read_nonempty: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_bytes != '0));

endmodule

// File: tb/tb_dma_addr_gen.sv
module tb_dma_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] p_src, p_dst;
    logic [15:0] p_len;
    logic [1:0]  p_sw, p_dw, p_st, p_dt, p_sm, p_dm;
    logic [4:0]  p_sid, p_did;
    logic [31:0] dev_req;
    logic        rd_req, rd_ack, wr_req, wr_ack;
    logic [31:0] rd_addr, wr_addr, rd_data, wr_data;
    logic [2:0]  rd_bytes, wr_bytes;
    logic        busy, mem_to_mem, done;
    logic [15:0] remaining;

    always #10 clk = ~clk;

    dma_addr_gen dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_src_addr(p_src), .cfg_dst_addr(p_dst), .cfg_len(p_len),
        .cfg_src_width(p_sw), .cfg_dst_width(p_dw),
        .cfg_src_tsize(p_st), .cfg_dst_tsize(p_dt),
        .cfg_src_mode(p_sm), .cfg_dst_mode(p_dm),
        .cfg_src_dev(p_sid), .cfg_dst_dev(p_did), .dev_req(dev_req),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_bytes(rd_bytes),
        .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_bytes(wr_bytes),
        .wr_data(wr_data), .wr_ack(wr_ack),
        .busy(busy), .mem_to_mem(mem_to_mem), .remaining(remaining), .done(done));

    int errors = 0;
    int checks = 0;

    // expectation state, independent of the port drivers
    logic [31:0] e_src, e_dst;
    int          e_len;
    logic [1:0]  e_sw, e_dw, e_st, e_dt, e_sm, e_dm;
    int          ri, wi, rbytes, wbytes;
    bit          done_seen;
    bit          rand_req;
    int          salt;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int wb(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    function automatic int gb(input logic [1:0] c);
        return 1 << c;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [1:0] m,
                                             input logic [1:0] w, input logic [1:0] t, input int k);
        case (m)
            2'd1:    return base;
            2'd2:    return base + 32'((k % gb(t)) * wb(w));
            default: return base + 32'(k * wb(w));
        endcase
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        return (m == 2'd1) ? "R4" : (m == 2'd2) ? "R5" : "R3";
    endfunction

    function automatic logic [7:0] sbyte(input int k);
        return 8'(k * 37 + 11 + salt);
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // one bus cycle: sample at the falling edge, answer for the next rising edge
    task automatic service();
        int n;
        logic [31:0] d, m;
        @(negedge clk);
        rd_ack = 1'b0;
        wr_ack = 1'b0;
        if (rand_req) dev_req = $urandom;
        if (done) done_seen = 1'b1;
        if (busy)
            chk(remaining == 16'(e_len - wbytes), "R9 remaining", 32'(remaining), 32'(e_len - wbytes));
        if (rd_req && wr_req) chk(1'b0, "R12 both requests", 32'd1, 32'd0);
        if (rd_req) begin
            n = imin(wb(e_sw), e_len - rbytes);
            chk(rd_addr == exp_addr(e_src, e_sm, e_sw, e_st, ri), mode_tag(e_sm),
                rd_addr, exp_addr(e_src, e_sm, e_sw, e_st, ri));
            chk(int'(rd_bytes) == n, "R1 read size", 32'(rd_bytes), 32'(n));
            if (($urandom % 10) < 7) begin
                d = $urandom;
                for (int b = 0; b < n; b++) d[b*8 +: 8] = sbyte(rbytes + b);
                rd_data = d;
                rd_ack  = 1'b1;
                rbytes += n;
                ri++;
            end
        end else if (wr_req) begin
            n = imin(wb(e_dw), e_len - wbytes);
            chk(wr_addr == exp_addr(e_dst, e_dm, e_dw, e_dt, wi), mode_tag(e_dm),
                wr_addr, exp_addr(e_dst, e_dm, e_dw, e_dt, wi));
            chk(int'(wr_bytes) == n, "R8 write size", 32'(wr_bytes), 32'(n));
            d = '0;
            m = '0;
            for (int b = 0; b < n; b++) begin
                d[b*8 +: 8] = sbyte(wbytes + b);
                m[b*8 +: 8] = 8'hFF;
            end
            chk((wr_data & m) == d, "R8 write data", wr_data & m, d);
            if (($urandom % 10) < 7) begin
                wr_ack = 1'b1;
                wbytes += n;
                wi++;
            end
        end
    endtask

    task automatic begin_xfer(input logic [31:0] s, input logic [31:0] dd, input int len,
                              input logic [1:0] sw, input logic [1:0] dw,
                              input logic [1:0] st, input logic [1:0] dt,
                              input logic [1:0] sm, input logic [1:0] dm,
                              input logic [4:0] sid, input logic [4:0] did);
        bit exp_m2m;
        @(negedge clk);
        e_src = s; e_dst = dd; e_len = len;
        e_sw = sw; e_dw = dw; e_st = st; e_dt = dt; e_sm = sm; e_dm = dm;
        ri = 0; wi = 0; rbytes = 0; wbytes = 0; done_seen = 1'b0;
        salt = int'($urandom % 256);
        p_src = s; p_dst = dd; p_len = 16'(len);
        p_sw = sw; p_dw = dw; p_st = st; p_dt = dt; p_sm = sm; p_dm = dm;
        p_sid = sid; p_did = did;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_m2m = (sid >= 5'd30) && (did >= 5'd30);
        if (len != 0) begin
            chk(mem_to_mem == exp_m2m, "R7 mem_to_mem", 32'(mem_to_mem), 32'(exp_m2m));
            chk(busy == 1'b1, "R9 busy after start", 32'(busy), 32'd1);
        end
        if (done) done_seen = 1'b1;
    endtask

    task automatic finish_xfer(input bit inject);
        int n = 0;
        while (!done_seen && n < 4000) begin
            service();
            n++;
            if (inject && n == 5) begin
                chk(busy == 1'b1, "R11 busy before second start", 32'(busy), 32'd1);
                start = 1'b1;
                p_len = p_len + 16'd9;
                p_src = p_src ^ 32'h00F0_0000;
                p_sw  = 2'd2;
                p_sm  = 2'd1;
            end
            if (n == 6) start = 1'b0;
        end
        chk(done_seen, "R9 done seen", 32'(done_seen), 32'd1);
        chk(!busy && remaining == 16'd0, "R9 idle after done", 32'(remaining), 32'd0);
        chk(wbytes == e_len && rbytes == e_len, "R8 byte totals", 32'(wbytes), 32'(e_len));
        @(negedge clk);
        chk(!done, "R9 done one cycle", 32'(done), 32'd0);
    endtask

    task automatic run(input logic [31:0] s, input logic [31:0] dd, input int len,
                       input logic [1:0] sw, input logic [1:0] dw,
                       input logic [1:0] st, input logic [1:0] dt,
                       input logic [1:0] sm, input logic [1:0] dm,
                       input logic [4:0] sid, input logic [4:0] did, input bit inject);
        begin_xfer(s, dd, len, sw, dw, st, dt, sm, dm, sid, did);
        finish_xfer(inject);
    endtask

    function automatic logic [4:0] pick_id();
        int r = int'($urandom % 4);
        return (r == 0) ? 5'd31 : (r == 1) ? 5'd30 : 5'($urandom % 30);
    endfunction

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h5EED);
        rst = 1'b1; start = 1'b0; dev_req = '0; rd_ack = 1'b0; wr_ack = 1'b0; rd_data = '0;
        rand_req = 1'b1;
        p_src = '0; p_dst = '0; p_len = '0; p_sw = '0; p_dw = '0; p_st = '0; p_dt = '0;
        p_sm = '0; p_dm = '0; p_sid = '0; p_did = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(!busy && !done && !rd_req && !wr_req && remaining == 16'd0, "R13 reset state",
            {busy, done, rd_req, wr_req}, 32'd0);

        // R10 zero length
        begin_xfer(32'h100, 32'h200, 0, 2'd2, 2'd2, 2'd3, 2'd3, 2'd0, 2'd0, 5'd31, 5'd31);
        chk(done && !busy, "R10 zero-length done", {done, busy}, 32'b10);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(!rd_req && !wr_req && !busy, "R10 no requests", {rd_req, wr_req, busy}, 32'd0);
        end

        // word to word memory copy, R7 flag set
        run(32'h1000, 32'h2000, 16, 2'd2, 2'd2, 2'd3, 2'd3, 2'd0, 2'd0, 5'd31, 5'd30, 1'b0);
        // byte to word packing with odd tail, R1 R8
        run(32'h1100, 32'h2100, 7, 2'd0, 2'd3, 2'd1, 2'd2, 2'd3, 2'd0, 5'd31, 5'd31, 1'b0);
        // word to byte unpacking into a fixed FIFO, R4
        run(32'h1200, 32'h4000_0010, 9, 2'd2, 2'd0, 2'd3, 2'd2, 2'd0, 2'd1, 5'd30, 5'd12, 1'b0);
        // halfword burst FIFO source, R5
        run(32'h5000_0000, 32'h2300, 22, 2'd1, 2'd2, 2'd1, 2'd3, 2'd2, 2'd0, 5'd7, 5'd31, 1'b0);

        // R6 and R2: pacing by one request per group of four
        rand_req = 1'b0;
        dev_req = '0;
        begin_xfer(32'h6000_0000, 32'h2400, 10, 2'd0, 2'd2, 2'd2, 2'd0, 2'd1, 2'd0, 5'd5, 5'd31);
        repeat (30) service();
        chk(rbytes == 0, "R6 no beat without request", 32'(rbytes), 32'd0);
        dev_req = 32'd1 << 5;
        service();
        dev_req = '0;
        repeat (30) service();
        chk(rbytes == 4, "R2 R6 one group per request", 32'(rbytes), 32'd4);
        dev_req = 32'd1 << 5;
        service();
        dev_req = '0;
        repeat (30) service();
        chk(rbytes == 8, "R6 second group", 32'(rbytes), 32'd8);
        dev_req = 32'd1 << 5;
        service();
        dev_req = '0;
        finish_xfer(1'b0);
        chk(ri == 10, "R6 tail group shortened", 32'(ri), 32'd10);
        rand_req = 1'b1;

        // R11: second start during a transfer has no effect
        run(32'h3000, 32'h7000, 24, 2'd0, 2'd1, 2'd3, 2'd3, 2'd0, 2'd2, 5'd31, 5'd31, 1'b1);

        // randomised transfers
        for (int t = 0; t < 40; t++) begin
            run($urandom & 32'hFFFF_FFF0, $urandom & 32'hFFFF_FFF0, 1 + int'($urandom % 40),
                2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                2'($urandom), 2'($urandom), pick_id(), pick_id(), 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule